// File: doc/BRIEF.md
# Flash Status Error-Flag Clear Logic

This block holds the error and progress bits of a serial flash status register and applies the clear-status instruction to them. A serial front end delivers instruction bits one at a time. Each bit arrives as a strobe on `bit_valid`, sampled in the system clock domain, together with the active-low chip select. The block gathers those bits into an instruction byte. When chip select returns high, it decides whether a complete instruction was framed.

The program and erase engines are modelled here by strobe inputs. `engine_busy` reports an operation in flight. `erase_fail_set` and `prog_fail_set` mark a failed operation. The clear instruction resets both failure flags. It needs no prior write enable, it is accepted while the device reports busy, and it leaves the write-enable latch as it was. A latched failure holds the busy bit high, so clearing the flags lets the busy bit fall once the engine is idle. The write-enable and write-disable instructions use the same framing and drive the latch.

Top module: `sr_clear_ctrl`

## Requirements
- R1: After reset, `status_byte` is 8'h00.
- R2: Bits count only while `cs_n` is low and are shifted in most significant bit first. An instruction executes only when `cs_n` rises after exactly 8 counted bits. A frame of 7 bits, or of 9 or more bits, does nothing.
- R3: A framed instruction 8'h30 clears status bit 5 (erase failure) and bit 6 (program failure). The new value is visible after the second rising clock edge that samples `cs_n` high.
- R4: The clear instruction takes effect while the write-enable latch is 0.
- R5: The clear instruction takes effect while `engine_busy` is 1 and status bit 0 reads 1.
- R6: The clear instruction leaves status bit 1 (write-enable latch) unchanged, whether it was 0 or 1.
- R7: Status bit 0 (write in progress) is 1 whenever `engine_busy` is 1 or either failure flag is set, and 0 otherwise. Clearing the flags with the engine idle makes it fall.
- R8: If a failure-set strobe is high in the same cycle that a clear applies, the set wins and that flag stays 1.
- R9: A framed 8'h06 sets status bit 1 and a framed 8'h04 clears it. Both use the same timing as R3.
- R10: Any other framed byte changes nothing. Bit strobes while `cs_n` is high are ignored.
- R11: The layout of `status_byte` is: bit 0 write in progress, bit 1 write-enable latch, bit 5 erase failure, bit 6 program failure. Bits 2, 3, 4 and 7 read 0.
- R12: A high `erase_fail_set` or `prog_fail_set` sets bit 5 or bit 6 respectively at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select from the serial front end |
| bit_valid | input | 1 | One instruction bit is present this cycle |
| bit_data | input | 1 | Value of the instruction bit |
| engine_busy | input | 1 | A program or erase operation is running |
| erase_fail_set | input | 1 | Erase engine reports a failure |
| prog_fail_set | input | 1 | Program engine reports a failure |
| status_byte | output | 8 | Status byte for read-back |

## Verification
The checker tests several properties on every cycle:
- A set strobe always leaves its flag high on the next cycle.
- A clear with no competing set always drops the flags.
- The latch keeps its value across a clear.
- A flag falls only after a clear strobe, and a strobe follows only a chip-select rise.
- Busy stays high while a flag is set, and the reserved bits stay zero.

Only the bench's scenarios can show which frames decode. These cover bit counts of 7, 8 and 9, the three opcodes against an unrelated byte, and bits that arrive while the chip is deselected. The scenarios also pin down the exact cycle in which a clear lands, and show the set-versus-clear race in that cycle.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int STAT_W    = 8;
  localparam int WIP_POS   = 0;
  localparam int WEL_POS   = 1;
  localparam int EFAIL_POS = 5;
  localparam int PFAIL_POS = 6;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_CLEAR = 2'd1,
    CMD_WREN  = 2'd2,
    CMD_WRDI  = 2'd3
  } cmd_kind_e;

  typedef struct packed {
    logic pfail;
    logic efail;
    logic wel;
    logic wip;
  } stat_bits_t;

  // Build the read-back byte from individual bits.
  function automatic logic [STAT_W-1:0] pack_status(input stat_bits_t s);
    logic [STAT_W-1:0] b;
    b            = '0;
    b[WIP_POS]   = s.wip;
    b[WEL_POS]   = s.wel;
    b[EFAIL_POS] = s.efail;
    b[PFAIL_POS] = s.pfail;
    return b;
  endfunction

  // Sticky flag update: a set outranks a clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Busy is reported while an engine runs or a failure is latched.
  function automatic logic busy_view(input logic eng, input logic ef, input logic pf);
    return eng | ef | pf;
  endfunction
endpackage

// File: rtl/sr_bit_shifter.sv
module sr_bit_shifter #(
  parameter int CMD_BITS = 8,
  parameter int CNT_W    = $clog2(CMD_BITS + 2)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                bit_valid,
  input  logic                bit_data,
  output logic [CMD_BITS-1:0] shift_q,
  output logic [CNT_W-1:0]    cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (cs_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (bit_valid) begin
      shift_q <= {shift_q[CMD_BITS-2:0], bit_data};
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sr_cmd_decode.sv
module sr_cmd_decode
  import sr_pkg::*;
#(
  parameter int               CMD_BITS = 8,
  parameter int               CNT_W    = $clog2(CMD_BITS + 2),
  parameter logic [CMD_BITS-1:0] OP_CLEAR = 8'h30,
  parameter logic [CMD_BITS-1:0] OP_WREN  = 8'h06,
  parameter logic [CMD_BITS-1:0] OP_WRDI  = 8'h04
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic [CMD_BITS-1:0] shift_q,
  input  logic [CNT_W-1:0]    cnt_q,
  output logic                cs_rise,
  output logic                frame_ok,
  output logic                clr_stb,
  output logic                wren_stb,
  output logic                wrdi_stb
);
  logic      cs_q;
  cmd_kind_e kind;

  assign cs_rise  = cs_n & ~cs_q;
  assign frame_ok = cs_rise && (cnt_q == CNT_W'(CMD_BITS));

  always_comb begin
    kind = CMD_NONE;
    if (frame_ok) begin
      if (shift_q == OP_CLEAR)     kind = CMD_CLEAR;
      else if (shift_q == OP_WREN) kind = CMD_WREN;
      else if (shift_q == OP_WRDI) kind = CMD_WRDI;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      clr_stb  <= 1'b0;
      wren_stb <= 1'b0;
      wrdi_stb <= 1'b0;
    end else begin
      cs_q     <= cs_n;
      clr_stb  <= (kind == CMD_CLEAR);
      wren_stb <= (kind == CMD_WREN);
      wrdi_stb <= (kind == CMD_WRDI);
    end
  end
endmodule

// File: rtl/sr_flag_bank.sv
module sr_flag_bank
  import sr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_stb,
  input  logic wren_stb,
  input  logic wrdi_stb,
  input  logic efail_set,
  input  logic pfail_set,
  input  logic engine_busy,
  output stat_bits_t bits
);
  logic efail_q, pfail_q, wel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      efail_q <= 1'b0;
      pfail_q <= 1'b0;
      wel_q   <= 1'b0;
    end else begin
      efail_q <= flag_next(efail_q, efail_set, clr_stb);
      pfail_q <= flag_next(pfail_q, pfail_set, clr_stb);
      if (wren_stb)      wel_q <= 1'b1;
      else if (wrdi_stb) wel_q <= 1'b0;
    end
  end

  always_comb begin
    bits.efail = efail_q;
    bits.pfail = pfail_q;
    bits.wel   = wel_q;
    bits.wip   = busy_view(engine_busy, efail_q, pfail_q);
  end
endmodule

// File: rtl/sr_clear_ctrl.sv
module sr_clear_ctrl
  import sr_pkg::*;
#(
  parameter int CMD_BITS = 8,
  parameter logic [CMD_BITS-1:0] OP_CLEAR = 8'h30,
  parameter logic [CMD_BITS-1:0] OP_WREN  = 8'h06,
  parameter logic [CMD_BITS-1:0] OP_WRDI  = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              bit_valid,
  input  logic              bit_data,
  input  logic              engine_busy,
  input  logic              erase_fail_set,
  input  logic              prog_fail_set,
  output logic [STAT_W-1:0] status_byte
);
  localparam int CNT_W = $clog2(CMD_BITS + 2);

  logic [CMD_BITS-1:0] shift_q;
  logic [CNT_W-1:0]    cnt_q;
  logic                cs_rise, frame_ok;
  logic                clr_stb, wren_stb, wrdi_stb;
  stat_bits_t          bits;

  sr_bit_shifter #(.CMD_BITS(CMD_BITS), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .bit_valid(bit_valid), .bit_data(bit_data),
    .shift_q(shift_q), .cnt_q(cnt_q)
  );

  sr_cmd_decode #(
    .CMD_BITS(CMD_BITS), .CNT_W(CNT_W),
    .OP_CLEAR(OP_CLEAR), .OP_WREN(OP_WREN), .OP_WRDI(OP_WRDI)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .shift_q(shift_q), .cnt_q(cnt_q),
    .cs_rise(cs_rise), .frame_ok(frame_ok),
    .clr_stb(clr_stb), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb)
  );

  sr_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n),
    .clr_stb(clr_stb), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .efail_set(erase_fail_set), .pfail_set(prog_fail_set),
    .engine_busy(engine_busy), .bits(bits)
  );

  assign status_byte = pack_status(bits);
endmodule

// File: rtl/sr_clear_checker.sv
module sr_clear_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       engine_busy,
  input logic       efail_set,
  input logic       pfail_set,
  input logic       clr_stb,
  input logic       wren_stb,
  input logic       wrdi_stb,
  input logic [7:0] status_byte
);
  AST_PSET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    pfail_set |=> status_byte[6]); // R8
  AST_ESET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    efail_set |=> status_byte[5]); // R12
  AST_CLEAR_DROPS_P: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !pfail_set) |=> !status_byte[6]); // R3
  AST_CLEAR_DROPS_E: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !efail_set) |=> !status_byte[5]); // R3
  AST_WEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> (status_byte[1] == $past(status_byte[1]))); // R6
  AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_byte[6]) |-> $past(clr_stb)); // R2
  AST_STROBE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |-> $past(cs_n)); // R2
  AST_WIP_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[5] || status_byte[6]) |-> status_byte[0]); // R7
  AST_WIP_FALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_byte[0]) |-> (!engine_busy && !status_byte[5] && !status_byte[6])); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clr_stb, wren_stb, wrdi_stb})); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[7] == 1'b0) && (status_byte[4:2] == 3'b000)); // R11
endmodule

bind sr_clear_ctrl sr_clear_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .engine_busy(engine_busy),
  .efail_set(erase_fail_set), .pfail_set(prog_fail_set),
  .clr_stb(clr_stb), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
  .status_byte(status_byte)
);

// File: tb/sr_clear_ctrl_test.sv
`timescale 1ns/1ps
module sr_clear_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       bit_valid = 1'b0;
  logic       bit_data = 1'b0;
  logic       engine_busy = 1'b0;
  logic       erase_fail_set = 1'b0;
  logic       prog_fail_set = 1'b0;
  logic [7:0] status_byte;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sr_clear_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .bit_valid(bit_valid),
    .bit_data(bit_data), .engine_busy(engine_busy),
    .erase_fail_set(erase_fail_set), .prog_fail_set(prog_fail_set),
    .status_byte(status_byte)
  );

  // Expected byte built from the layout in R11.
  function automatic logic [7:0] expect_byte(input logic wip, input logic wel,
                                             input logic ef, input logic pf);
    return {1'b0, pf, ef, 3'b000, wel, wip};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: status_byte actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] pattern, input int n);
    @(negedge clk) cs_n = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_data  = pattern[i];
      @(negedge clk);
      bit_valid = 1'b0;
    end
    @(negedge clk) cs_n = 1'b1;
  endtask

  task automatic frame(input logic [15:0] pattern, input int n);
    send_bits(pattern, n);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_flags(input logic ef, input logic pf);
    @(negedge clk);
    erase_fail_set = ef;
    prog_fail_set  = pf;
    @(negedge clk);
    erase_fail_set = 1'b0;
    prog_fail_set  = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1", status_byte, 8'h00);
  endtask

  task automatic t_set_flags;
    set_flags(1'b1, 1'b0);
    check("R12", status_byte, expect_byte(1, 0, 1, 0));
    set_flags(1'b0, 1'b1);
    check("R12", status_byte, expect_byte(1, 0, 1, 1));
  endtask

  task automatic t_clear_no_wel;
    frame(16'h0030, 8);
    check("R4", status_byte, expect_byte(0, 0, 0, 0));
  endtask

  task automatic t_clear_exact_cycle;
    set_flags(1'b1, 1'b1);
    send_bits(16'h0030, 8);
    @(posedge clk); #1;
    check("R3", status_byte, expect_byte(1, 0, 1, 1));
    @(posedge clk); #1;
    check("R3", status_byte, expect_byte(0, 0, 0, 0));
    repeat (2) @(negedge clk);
  endtask

  task automatic t_wel_kept;
    frame(16'h0006, 8);
    check("R9", status_byte, expect_byte(0, 1, 0, 0));
    set_flags(1'b1, 1'b1);
    frame(16'h0030, 8);
    check("R6", status_byte, expect_byte(0, 1, 0, 0));
    frame(16'h0004, 8);
    check("R9", status_byte, expect_byte(0, 0, 0, 0));
  endtask

  task automatic t_clear_busy;
    @(negedge clk) engine_busy = 1'b1;
    set_flags(1'b0, 1'b1);
    check("R7", status_byte, expect_byte(1, 0, 0, 1));
    frame(16'h0030, 8);
    check("R5", status_byte, expect_byte(1, 0, 0, 0));
    @(negedge clk) engine_busy = 1'b0;
    @(negedge clk);
    check("R7", status_byte, expect_byte(0, 0, 0, 0));
    set_flags(1'b1, 1'b0);
    check("R7", status_byte, expect_byte(1, 0, 1, 0));
    frame(16'h0030, 8);
    check("R7", status_byte, expect_byte(0, 0, 0, 0));
  endtask

  task automatic t_framing;
    set_flags(1'b1, 1'b1);
    frame(16'h0018, 7);   // 0011000 : 7 bits
    check("R2", status_byte, expect_byte(1, 0, 1, 1));
    frame(16'h0060, 9);   // 001100000 : last 8 bits read 60h
    check("R2", status_byte, expect_byte(1, 0, 1, 1));
    frame(16'h0030, 9);   // 000110000 : last 8 bits read 30h but 9 counted
    check("R2", status_byte, expect_byte(1, 0, 1, 1));
  endtask

  task automatic t_other_ops;
    frame(16'h0031, 8);
    check("R10", status_byte, expect_byte(1, 0, 1, 1));
    frame(16'h0003, 8);
    check("R10", status_byte, expect_byte(1, 0, 1, 1));
    // Bits while deselected, then a short selected frame: must not combine.
    @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_data  = 1'((8'h30 >> i) & 1);
      @(negedge clk);
      bit_valid = 1'b0;
    end
    repeat (3) @(negedge clk);
    check("R10", status_byte, expect_byte(1, 0, 1, 1));
    frame(16'h0000, 0);
    check("R10", status_byte, expect_byte(1, 0, 1, 1));
  endtask

  task automatic t_priority;
    send_bits(16'h0030, 8);
    @(negedge clk) prog_fail_set = 1'b1;
    @(negedge clk) prog_fail_set = 1'b0;
    @(negedge clk);
    check("R8", status_byte, expect_byte(1, 0, 0, 1));
    frame(16'h0030, 8);
    check("R11", status_byte, expect_byte(0, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_set_flags();
    t_clear_no_wel();
    t_clear_exact_cycle();
    t_wel_kept();
    t_clear_busy();
    t_framing();
    t_other_ops();
    t_priority();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule